// File: doc/BRIEF.md
# Sleep Mode and Wake-Up Controller

This controller sits next to a small CPU core and handles low-power sleep. When the core issues a one-cycle sleep strobe while the sleep-enable control bit is set, the controller latches the two-bit mode select. It then gates the CPU, flash, I/O, ADC and fast peripheral clock enables and the main-oscillator enable for that mode. While the core sleeps, the controller watches a vector of wake requests and a reset request. Each mode accepts only its own subset of wake sources.

After an accepted interrupt wake, the controller can wait a start-up delay that is counted on the main clock. It then holds the CPU halted with all clocks running for a fixed number of cycles. Finally it pulses a flag that tells the core to service the interrupt and resume after the sleep instruction. A reset request skips the extra halt and pulses a reset-vector flag instead.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A sleep strobe sampled with sleep_en low has no effect: cpu_halt stays 0, every clock enable and osc_en stay 1, and adc_start stays 0.
- R2: A sleep strobe with sleep_en high enters sleep one cycle later. The clock enables, in the order {cpu, flash, io, adc, pck, osc}, depend on mode_sel:
  - 00 (Idle) gives 001111.
  - 01 (ADC noise reduction) gives 000111.
  - 10 (Power-down) gives 000000.
  - 11 (Stand-by) gives 000001.
- R3: In Idle, any of the six wake_req bits wakes the core. The bits are: 0 ADC done, 1 memory ready, 2 INT0 level, 3 pin change, 4 watchdog interrupt, 5 any other interrupt.
- R4: In ADC noise reduction, only wake_req bits 0 to 3 wake the core. Bits 4 and 5 are ignored, and the core stays asleep with unchanged enables.
- R5: In Power-down and Stand-by, only wake_req bits 2, 3 and 4 wake the core. Bits 0, 1 and 5 are ignored.
- R6: After a Power-down wake, osc_en is 1 and the other enables are 0 for STARTUP_CYCLES cycles. Idle, ADC noise reduction and Stand-by have no start-up phase.
- R7: After an interrupt wake and any start-up phase, the following sequence occurs:
  - For WAKE_HALT_CYCLES cycles, all enables are 1 and cpu_halt is 1.
  - Next, cpu_halt falls and irq_resume pulses for exactly one cycle.
- R8: A reset_req during sleep wakes the core from every mode. After any start-up phase, cpu_halt falls and reset_resume pulses for one cycle. There is no extra halt and no irq_resume.
- R9: Entering Idle or ADC noise reduction with adc_en high pulses adc_start for one cycle, in the first sleep cycle. The other modes, or adc_en low, give no pulse.
- R10: Wake and reset requests pass a two-flop synchronizer. A request raised before edge k takes effect at edge k+2, so the sleep enables hold for two more cycles.
- R11: A sleep strobe during sleep, start-up or halt is ignored. Wake requests while running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| sleep_en | input | 1 | Sleep-enable control bit |
| mode_sel | input | 2 | Sleep mode select |
| sleep_strobe | input | 1 | One-cycle sleep-instruction strobe |
| adc_en | input | 1 | ADC is enabled |
| wake_req | input | 6 | Per-source wake/interrupt requests (asynchronous) |
| reset_req | input | 1 | Combined external/watchdog/brown-out reset request (asynchronous) |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| clk_pck_en | output | 1 | Fast peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| cpu_halt | output | 1 | CPU halted |
| adc_start | output | 1 | Automatic ADC conversion start pulse |
| irq_resume | output | 1 | Pulse: service the interrupt, then resume after sleep |
| reset_resume | output | 1 | Pulse: execute from the reset vector |

## Verification
The bench builds the block with STARTUP_CYCLES set to 3 and WAKE_HALT_CYCLES kept at 4. With these values, every Power-down wake walks through the start-up phase and the halt phase in a few cycles. That makes it practical to sweep all four modes against all six wake sources plus the reset request, with adc_en both low and high. Each ignored source is held across several cycles, together with a stray sleep strobe, before a permitted source ends the sleep. This checks both the no-effect cases and the exact cycle of every enable change.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int STARTUP_CYCLES   = 16,
  parameter int WAKE_HALT_CYCLES = 4,
  parameter int NUM_WAKE         = 6,
  parameter logic [NUM_WAKE-1:0] IDLE_WAKE_MASK = 6'b111111,
  parameter logic [NUM_WAKE-1:0] NR_WAKE_MASK   = 6'b001111,
  parameter logic [NUM_WAKE-1:0] PD_WAKE_MASK   = 6'b011100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_en,
  input  logic [1:0]          mode_sel,
  input  logic                sleep_strobe,
  input  logic                adc_en,
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic                reset_req,
  output logic                clk_cpu_en,
  output logic                clk_flash_en,
  output logic                clk_io_en,
  output logic                clk_adc_en,
  output logic                clk_pck_en,
  output logic                osc_en,
  output logic                cpu_halt,
  output logic                adc_start,
  output logic                irq_resume,
  output logic                reset_resume
);

  localparam int CNT_MAX = (STARTUP_CYCLES > WAKE_HALT_CYCLES) ? STARTUP_CYCLES : WAKE_HALT_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] START_LOAD = CW'((STARTUP_CYCLES > 0) ? STARTUP_CYCLES - 1 : 0);
  localparam logic [CW-1:0] HALT_LOAD  = CW'((WAKE_HALT_CYCLES > 0) ? WAKE_HALT_CYCLES - 1 : 0);

  localparam logic [1:0] M_IDLE = 2'b00;
  localparam logic [1:0] M_NR   = 2'b01;
  localparam logic [1:0] M_PD   = 2'b10;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_START, ST_HALT} st_t;

  st_t                 state_q;
  logic [1:0]          mode_q;
  logic                by_reset_q;
  logic [CW-1:0]       cnt_q;
  logic [NUM_WAKE:0]   sync1_q, sync2_q;
  logic                adc_start_q, irq_q, rstgo_q;
  logic [NUM_WAKE-1:0] mask;
  logic                wake_hit, rst_hit, needs_start, running;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= {reset_req, wake_req};
      sync2_q <= sync1_q;
    end

  always_comb
    case (mode_q)
      M_IDLE:  mask = IDLE_WAKE_MASK;
      M_NR:    mask = NR_WAKE_MASK;
      default: mask = PD_WAKE_MASK;
    endcase

  assign rst_hit     = sync2_q[NUM_WAKE];
  assign wake_hit    = |(sync2_q[NUM_WAKE-1:0] & mask);
  assign needs_start = (mode_q == M_PD) && (STARTUP_CYCLES > 0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q     <= ST_RUN;
      mode_q      <= M_IDLE;
      by_reset_q  <= 1'b0;
      cnt_q       <= '0;
      adc_start_q <= 1'b0;
      irq_q       <= 1'b0;
      rstgo_q     <= 1'b0;
    end else begin
      adc_start_q <= 1'b0;
      irq_q       <= 1'b0;
      rstgo_q     <= 1'b0;
      case (state_q)
        ST_RUN:
          if (sleep_strobe && sleep_en) begin
            state_q     <= ST_SLEEP;
            mode_q      <= mode_sel;
            adc_start_q <= adc_en && !mode_sel[1];
          end
        ST_SLEEP:
          if (rst_hit || wake_hit) begin
            by_reset_q <= rst_hit;
            if (needs_start) begin
              state_q <= ST_START;
              cnt_q   <= START_LOAD;
            end else if (rst_hit) begin
              state_q <= ST_RUN;
              rstgo_q <= 1'b1;
            end else begin
              state_q <= ST_HALT;
              cnt_q   <= HALT_LOAD;
            end
          end
        ST_START:
          if (cnt_q == '0) begin
            if (by_reset_q) begin
              state_q <= ST_RUN;
              rstgo_q <= 1'b1;
            end else begin
              state_q <= ST_HALT;
              cnt_q   <= HALT_LOAD;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        default:
          if (cnt_q == '0) begin
            state_q <= ST_RUN;
            irq_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
      endcase
    end

  assign running      = (state_q == ST_RUN) || (state_q == ST_HALT);
  assign clk_cpu_en   = running;
  assign clk_flash_en = running;
  assign clk_io_en    = running || (state_q == ST_SLEEP && mode_q == M_IDLE);
  assign clk_adc_en   = running || (state_q == ST_SLEEP && !mode_q[1]);
  assign clk_pck_en   = running || (state_q == ST_SLEEP && !mode_q[1]);
  assign osc_en       = !(state_q == ST_SLEEP && mode_q == M_PD);
  assign cpu_halt     = (state_q != ST_RUN);
  assign adc_start    = adc_start_q;
  assign irq_resume   = irq_q;
  assign reset_resume = rstgo_q;

  p_noop_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_strobe && !sleep_en) |=> !cpu_halt);

  p_cpu_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |-> (!clk_cpu_en && !clk_flash_en && cpu_halt));

  p_start_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> (osc_en && !clk_io_en && !clk_cpu_en));

  p_halt_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> (clk_cpu_en && clk_io_en && osc_en && cpu_halt));

  p_irq_after_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_resume) |-> $past(state_q == ST_HALT));

  p_one_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_resume && reset_resume));

  p_adc_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  p_halt_if_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_cpu_en |-> cpu_halt);

endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
  localparam int SU = 3;
  localparam int HC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_en = 1'b0, sleep_strobe = 1'b0, adc_en = 1'b0, reset_req = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [5:0] wake_req = '0;
  logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_pck_en, osc_en;
  logic cpu_halt, adc_start, irq_resume, reset_resume;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.STARTUP_CYCLES(SU), .WAKE_HALT_CYCLES(HC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .sleep_strobe(sleep_strobe), .adc_en(adc_en), .wake_req(wake_req),
    .reset_req(reset_req), .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en),
    .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en), .clk_pck_en(clk_pck_en),
    .osc_en(osc_en), .cpu_halt(cpu_halt), .adc_start(adc_start),
    .irq_resume(irq_resume), .reset_resume(reset_resume));

  wire [5:0] ens = {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_pck_en, osc_en};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] sleep_vec(input int m);
    case (m)
      0: return 6'b001111;
      1: return 6'b000111;
      2: return 6'b000000;
      default: return 6'b000001;
    endcase
  endfunction

  function automatic bit allowed(input int m, input int src);
    if (src == 6) return 1'b1;
    if (m == 0) return 1'b1;
    if (m == 1) return src <= 3;
    return (src >= 2 && src <= 4);
  endfunction

  function automatic string wtag(input int m);
    return (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
  endfunction

  task automatic raise(input int src, input logic v);
    if (src == 6) reset_req = v; else wake_req[src] = v;
  endtask

  task automatic run_case(input int m, input int src, input logic adc);
    int s;
    s = src;
    @(negedge clk);
    mode_sel = 2'(m); sleep_en = 1'b1; adc_en = adc; sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0; sleep_en = 1'b0;
    chk("R2 sleep enables", ens, sleep_vec(m));
    chk("R2 halt in sleep", cpu_halt, 1);
    chk("R9 adc start pulse", adc_start, (adc && m < 2) ? 1 : 0);
    @(negedge clk);
    chk("R9 adc start one cycle", adc_start, 0);
    raise(s, 1'b1);
    if (!allowed(m, s)) begin
      repeat (3) @(negedge clk);
      mode_sel = 2'b00; sleep_en = 1'b1; sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0; sleep_en = 1'b0;
      repeat (4) @(negedge clk);
      chk({wtag(m), " ignored source"}, ens, sleep_vec(m));
      chk({wtag(m), " ignored source halt"}, {cpu_halt, irq_resume, reset_resume}, 3'b100);
      chk("R11 strobe during sleep", ens, sleep_vec(m));
      raise(s, 1'b0);
      s = 3;
      raise(s, 1'b1);
    end
    @(negedge clk);
    chk("R10 sync stage 1", ens, sleep_vec(m));
    @(negedge clk);
    chk("R10 sync stage 2", ens, sleep_vec(m));
    if (m == 2) begin
      for (int k = 0; k < SU; k++) begin
        @(negedge clk);
        chk("R6 start-up phase", {ens, cpu_halt}, 7'b0000011);
      end
    end
    if (s == 6) begin
      @(negedge clk);
      chk("R8 reset resume", {cpu_halt, irq_resume, reset_resume}, 3'b001);
      chk("R8 clocks on", ens, 6'b111111);
    end else begin
      for (int k = 0; k < HC; k++) begin
        @(negedge clk);
        chk({wtag(m), " R7 halt phase"}, {ens, cpu_halt, irq_resume}, 8'b11111110);
      end
      @(negedge clk);
      chk("R7 irq resume", {cpu_halt, irq_resume, reset_resume}, 3'b010);
    end
    @(negedge clk);
    chk("R7 R8 resume pulse one cycle", {irq_resume, reset_resume}, 0);
    repeat (2) @(negedge clk);
    chk("R11 wake while running", {ens, cpu_halt}, 7'b1111110);
    raise(s, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset state enables", ens, 6'b111111);
    chk("R2 reset state flags", {cpu_halt, adc_start, irq_resume, reset_resume}, 0);
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      mode_sel = 2'(m); sleep_en = 1'b0; adc_en = 1'b1; sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0;
      chk("R1 no-op strobe", {ens, cpu_halt, adc_start}, 8'b11111100);
      @(negedge clk);
      chk("R1 no-op strobe later", {ens, cpu_halt}, 7'b1111110);
    end
    for (int m = 0; m < 4; m++)
      for (int src = 0; src < 7; src++)
        for (int a = 0; a < 2; a++)
          run_case(m, src, a[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule